// File: doc/BRIEF.md
# Quad Simultaneous-Sampling Acquisition Sequencer

This block runs on the host side of a four-channel converter that samples all of its channels at the same instant and then returns the results through one shared 12-bit parallel port. A free-running divider, programmed with a period in system-clock cycles, marks the sample instants. On each mark the block drives a clean start pulse to the converter. It then waits for the converter's active-low completion interrupt and performs four read strobes, all to the same address. Chip select and read strobe follow minimum setup, width, access and spacing times, each turned into a whole number of system-clock cycles and rounded up.

The four words arrive in channel order. Each is a 12-bit two's complement value, and the block sign-extends it to 16 bits in a staging area. Once the fourth word is in, the block moves all four samples to its output at the same moment and pulses a one-cycle frame strobe. If the interrupt does not arrive within a programmable number of cycles after the start edge, the block raises a timeout pulse and goes back to idle without reading anything.

Top module: `quad_acq_sequencer`

## Requirements
- R1: While reset is held, the start output is low, chip select and read strobe are high (inactive), the frame output is all zeros, and the frame strobe and timeout pulse are low.
- R2: A start pulse stays high for ceil(50 ns / clock period) cycles (5 at the default 10 ns clock). While run is high and the sequencer is idle, successive start rising edges are exactly period cycles apart.
- R3: No start is issued until the previous sequence has finished or timed out. A period mark that arrives while a sequence is in progress is dropped.
- R4: No read begins until the synchronized interrupt has been seen low after the start.
- R5: Chip select goes low one cycle before the read strobe falls and stays low for one cycle after it rises. The read strobe stays low for max(ceil(60 ns/T), ceil(57 ns/T)) cycles, and the data word is captured on the edge that ends that low phase.
- R6: Each sequence makes exactly four reads. From one read strobe rising edge to the next falling edge is at least 130 ns.
- R7: The word from read k (k = 0..3, channel k+1) appears in frame bits [16k+15:16k].
- R8: Each 16-bit sample is its 12-bit word with bit 11 copied into bits 15..12.
- R9: The frame strobe is high for exactly one cycle per completed sequence. The frame output changes only together with that strobe and otherwise holds its value.
- R10: If the interrupt has not been seen low when the cycle count since the start rising edge reaches the timeout limit, the timeout output pulses for one cycle, (limit+1) cycles after that edge. The sequencer then returns to idle with no read and no change to the frame.
- R11: While run is low, no start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables periodic sampling |
| period_i | input | 16 | Sampling period in clock cycles |
| tmo_limit_i | input | 16 | Interrupt timeout in cycles from start edge |
| conv_start_o | output | 1 | Convert-start pulse to the converter |
| irq_n_i | input | 1 | Converter completion interrupt, active low |
| cs_n_o | output | 1 | Converter chip select, active low |
| rd_n_o | output | 1 | Converter read strobe, active low |
| adc_data_i | input | 12 | Converter data bus |
| frame_o | output | 64 | Four sign-extended samples, channel 1 in the low lane |
| frame_valid_o | output | 1 | One-cycle strobe when a new frame is presented |
| timeout_o | output | 1 | One-cycle pulse when the interrupt never arrived |

## Verification
The bench drives the block with a converter model that places a dummy word on the bus until 57 ns after each read strobe falls and releases the bus 20 ns after the strobe rises. A strobe that is too short therefore captures the dummy word and fails the comparison. The first frame carries the edge codes zero, largest positive, most negative and minus one, so it separates sign extension from plain zero padding. Later frames use mixed values, so a channel swap or an off-by-one lane shows up. Three patterns exercise the sequencer itself: a long period checks the exact start spacing; a period shorter than one sequence shows whether marks are dropped or a start lands during conversion; a silent converter exercises the timeout path and its timing.

// File: rtl/qacq_pkg.sv
`timescale 1ns/1ps
package qacq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_WAIT,
    S_SETUP,
    S_STROBE,
    S_HOLD,
    S_GAP,
    S_DONE
  } seq_state_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qacq_period_tick.sv
`timescale 1ns/1ps
module qacq_period_tick #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             tick
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = run && (({1'b0, cnt_q} + {{PER_W{1'b0}}, 1'b1}) >= {1'b0, period});
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;

endmodule

// File: rtl/qacq_bus_fsm.sv
`timescale 1ns/1ps
module qacq_bus_fsm
  import qacq_pkg::*;
#(
  parameter int TMO_W     = 16,
  parameter int NCH       = 4,
  parameter int START_CYC = 5,
  parameter int RD_CYC    = 6,
  parameter int GAP_CYC   = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [TMO_W-1:0]         tmo_limit,
  input  logic                     irq_n,
  output logic                     conv_o,
  output logic                     cs_n_o,
  output logic                     rd_n_o,
  output logic                     cap_o,
  output logic [$clog2(NCH)-1:0]   cap_idx_o,
  output logic                     publish_o,
  output logic                     timeout_o
);

  localparam int IDX_W = $clog2(NCH);
  localparam int CNT_W = TMO_W;
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_END    = CNT_W'(2 * START_CYC);
  localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CYC - 1);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(NCH - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [1:0]       irq_sync_q;
  logic             irq_lo;
  logic             conv_q, conv_d;
  logic             cs_n_q, cs_n_d;
  logic             rd_n_q, rd_n_d;
  logic             tmo_q, tmo_d;
  logic             cap, publish;

  assign irq_lo = !irq_sync_q[1];

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    idx_d   = idx_q;
    tmo_d   = 1'b0;
    cap     = 1'b0;
    publish = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        cnt_d = '0;
        if (tick) state_d = S_START;
      end
      S_START: begin
        if (cnt_q == START_LAST) state_d = S_WAIT;
      end
      S_WAIT: begin
        if (irq_lo) begin
          state_d = S_SETUP;
          idx_d   = '0;
        end else if (cnt_q >= LOW_END && cnt_q >= tmo_limit) begin
          state_d = S_IDLE;
          tmo_d   = 1'b1;
        end
      end
      S_SETUP: begin
        state_d = S_STROBE;
        cnt_d   = '0;
      end
      S_STROBE: begin
        if (cnt_q == RD_LAST) begin
          state_d = S_HOLD;
          cap     = 1'b1;
        end
      end
      S_HOLD: begin
        cnt_d   = '0;
        state_d = (idx_q == LAST_IDX) ? S_DONE : S_GAP;
      end
      S_GAP: begin
        if (cnt_q == GAP_LAST) begin
          state_d = S_SETUP;
          idx_d   = idx_q + 1'b1;
        end
      end
      S_DONE: begin
        state_d = S_IDLE;
        publish = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
    conv_d = (state_d == S_START);
    cs_n_d = !(state_d == S_SETUP || state_d == S_STROBE || state_d == S_HOLD);
    rd_n_d = (state_d != S_STROBE);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      irq_sync_q <= 2'b11;
      conv_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      rd_n_q     <= 1'b1;
      tmo_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      idx_q      <= idx_d;
      irq_sync_q <= {irq_sync_q[0], irq_n};
      conv_q     <= conv_d;
      cs_n_q     <= cs_n_d;
      rd_n_q     <= rd_n_d;
      tmo_q      <= tmo_d;
    end
  end

  assign conv_o    = conv_q;
  assign cs_n_o    = cs_n_q;
  assign rd_n_o    = rd_n_q;
  assign cap_o     = cap;
  assign cap_idx_o = idx_q;
  assign publish_o = publish;
  assign timeout_o = tmo_q;

  p_start_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_q) |-> $past(state_q) == S_IDLE);

  p_read_after_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n_q) && idx_q == '0) |-> $past(irq_lo));

  p_cs_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n_q) |-> $past(!cs_n_q));

  p_cs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n_q) |-> !cs_n_q);

  p_timeout_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (cs_n_q && rd_n_q));

endmodule

// File: rtl/qacq_frame_buf.sv
`timescale 1ns/1ps
module qacq_frame_buf #(
  parameter int NCH   = 4,
  parameter int ADC_W = 12,
  parameter int OUT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap,
  input  logic [$clog2(NCH)-1:0] cap_idx,
  input  logic [ADC_W-1:0]       bus_data,
  input  logic                   publish,
  output logic [NCH*OUT_W-1:0]   frame_o,
  output logic                   valid_o
);

  localparam int IDX_W = $clog2(NCH);
  localparam int EXT_W = OUT_W - ADC_W;

  logic [OUT_W-1:0]     stage_q [NCH];
  logic [NCH*OUT_W-1:0] frame_q;
  logic                 valid_q;
  logic [OUT_W-1:0]     word_ext;

  assign word_ext = {{EXT_W{bus_data[ADC_W-1]}}, bus_data};

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    logic load;
    assign load = cap && (cap_idx == IDX_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stage_q[k] <= '0;
      else if (load) stage_q[k] <= word_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       frame_q[k*OUT_W +: OUT_W] <= '0;
      else if (publish) frame_q[k*OUT_W +: OUT_W] <= stage_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= publish;
  end

  assign frame_o = frame_q;
  assign valid_o = valid_q;

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  p_frame_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(frame_q));

endmodule

// File: rtl/quad_acq_sequencer.sv
`timescale 1ns/1ps
module quad_acq_sequencer
  import qacq_pkg::*;
#(
  parameter int CLK_NS       = 10,
  parameter int START_MIN_NS = 50,
  parameter int RD_MIN_NS    = 60,
  parameter int ACCESS_NS    = 57,
  parameter int GAP_MIN_NS   = 130,
  parameter int NCH          = 4,
  parameter int ADC_W        = 12,
  parameter int OUT_W        = 16,
  parameter int PER_W        = 16,
  parameter int TMO_W        = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_i,
  input  logic [PER_W-1:0]     period_i,
  input  logic [TMO_W-1:0]     tmo_limit_i,
  output logic                 conv_start_o,
  input  logic                 irq_n_i,
  output logic                 cs_n_o,
  output logic                 rd_n_o,
  input  logic [ADC_W-1:0]     adc_data_i,
  output logic [NCH*OUT_W-1:0] frame_o,
  output logic                 frame_valid_o,
  output logic                 timeout_o
);

  localparam int START_CYC = imax(cdiv(START_MIN_NS, CLK_NS), 1);
  localparam int RD_CYC    = imax(imax(cdiv(RD_MIN_NS, CLK_NS), cdiv(ACCESS_NS, CLK_NS)), 1);
  localparam int GAP_CYC   = imax(cdiv(GAP_MIN_NS, CLK_NS) - 2, 1);
  localparam int IDX_W     = $clog2(NCH);

  logic             tick;
  logic             cap;
  logic [IDX_W-1:0] cap_idx;
  logic             publish;

  qacq_period_tick #(.PER_W(PER_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_i),
    .period (period_i),
    .tick   (tick)
  );

  qacq_bus_fsm #(
    .TMO_W     (TMO_W),
    .NCH       (NCH),
    .START_CYC (START_CYC),
    .RD_CYC    (RD_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tmo_limit (tmo_limit_i),
    .irq_n     (irq_n_i),
    .conv_o    (conv_start_o),
    .cs_n_o    (cs_n_o),
    .rd_n_o    (rd_n_o),
    .cap_o     (cap),
    .cap_idx_o (cap_idx),
    .publish_o (publish),
    .timeout_o (timeout_o)
  );

  qacq_frame_buf #(
    .NCH   (NCH),
    .ADC_W (ADC_W),
    .OUT_W (OUT_W)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .cap_idx  (cap_idx),
    .bus_data (adc_data_i),
    .publish  (publish),
    .frame_o  (frame_o),
    .valid_o  (frame_valid_o)
  );

endmodule

// File: tb/quad_acq_sequencer_tb.sv
`timescale 1ns/1ps
module quad_acq_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CONV_NS    = 2000;

  logic        clk;
  logic        rst_n;
  logic        run;
  logic [15:0] period;
  logic [15:0] tmo_limit;
  logic        conv;
  logic        irq_n;
  logic        cs_n;
  logic        rd_n;
  logic [11:0] bus;
  logic [63:0] frame;
  logic        fvalid;
  logic        tmo;

  quad_acq_sequencer u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run),
    .period_i      (period),
    .tmo_limit_i   (tmo_limit),
    .conv_start_o  (conv),
    .irq_n_i       (irq_n),
    .cs_n_o        (cs_n),
    .rd_n_o        (rd_n),
    .adc_data_i    (bus),
    .frame_o       (frame),
    .frame_valid_o (fvalid),
    .timeout_o     (tmo)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic logic [15:0] sext(input logic [11:0] w);
    return {{4{w[11]}}, w};
  endfunction

  function automatic logic [11:0] pick(input int f, input int k);
    if (f == 0) begin
      case (k)
        0: return 12'h000;
        1: return 12'h7FF;
        2: return 12'h800;
        default: return 12'hFFF;
      endcase
    end
    return 12'((f * 1123 + k * 467 + 5) % 4096);
  endfunction

  // converter model and scoreboard driver
  bit          armed = 0;
  bit          mute = 0;
  bit          busy = 0;
  bit          chk_period = 0;
  bit          have_prev = 0;
  int          frame_no = 0;
  int          ridx = 0;
  int          n_starts = 0;
  int          cs_falls = 0;
  int          n_tmo = 0;
  realtime     t_conv, t_prev_conv, t_rdfall, t_rdrise, t_tmo;
  logic [11:0] words [4];
  logic [63:0] exp_q [$];

  always @(posedge conv) begin
    if (armed) begin
      check(!busy, "R3 start while converting", 64'(busy), 64'(0));
      if (chk_period && have_prev)
        check(int'($realtime - t_prev_conv) == int'(period) * CLK_PERIOD, "R2 start spacing",
              64'(int'($realtime - t_prev_conv)), 64'(int'(period) * CLK_PERIOD));
      have_prev   = 1;
      t_prev_conv = $realtime;
      t_conv      = $realtime;
      n_starts++;
      ridx = 0;
      if (!mute) begin
        busy = 1;
        for (int k = 0; k < 4; k++) words[k] = pick(frame_no, k);
        exp_q.push_back({sext(words[3]), sext(words[2]), sext(words[1]), sext(words[0])});
        frame_no++;
        irq_n <= #(CONV_NS) 1'b0;
      end
    end
  end

  always @(negedge irq_n) busy = 0;

  always @(negedge conv) begin
    if (armed)
      check(($realtime - t_conv) >= 50.0, "R2 start width", 64'(int'($realtime - t_conv)), 64'(50));
  end

  always @(negedge cs_n) if (armed) cs_falls++;

  always @(negedge rd_n) begin
    if (armed) begin
      check(cs_n == 1'b0, "R5 chip select setup", 64'(cs_n), 64'(0));
      check(!(ridx == 0 && irq_n == 1'b1), "R4 read before interrupt", 64'(irq_n), 64'(0));
      check(ridx < 4, "R6 read count", 64'(ridx), 64'(3));
      if (ridx > 0)
        check(($realtime - t_rdrise) >= 130.0, "R6 read gap", 64'(int'($realtime - t_rdrise)), 64'(130));
      if (ridx == 0) irq_n = 1'b1;
      t_rdfall = $realtime;
      bus = 12'hBAD;
      bus <= #57 words[(ridx < 4) ? ridx : 0];
    end
  end

  always @(posedge rd_n) begin
    if (armed) begin
      check(($realtime - t_rdfall) >= 60.0, "R5 read width", 64'(int'($realtime - t_rdfall)), 64'(60));
      check(cs_n == 1'b0, "R5 chip select hold", 64'(cs_n), 64'(0));
      ridx++;
      t_rdrise = $realtime;
      bus <= #20 12'hBAD;
    end
  end

  always @(posedge tmo) begin
    if (armed) begin
      n_tmo++;
      t_tmo = $realtime;
    end
  end

  // monitor
  int          frames_seen = 0;
  int          hold_bad = 0;
  bit          have_last = 0;
  bit          valid_prev = 0;
  bit          tmo_prev = 0;
  logic [63:0] last_frame = '0;

  always @(negedge clk) begin
    if (armed && rst_n) begin
      if (valid_prev) check(!fvalid, "R9 strobe width", 64'(fvalid), 64'(0));
      if (tmo_prev)   check(!tmo, "R10 timeout pulse width", 64'(tmo), 64'(0));
      if (fvalid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected frame", frame, 64'(0));
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          for (int k = 0; k < 4; k++)
            check(frame[16*k +: 16] == e[16*k +: 16], $sformatf("R7 R8 lane %0d", k),
                  64'(frame[16*k +: 16]), 64'(e[16*k +: 16]));
        end
        last_frame = frame;
        have_last  = 1;
        frames_seen++;
      end else if (have_last && frame != last_frame) begin
        hold_bad++;
      end
      valid_prev = fvalid;
      tmo_prev   = tmo;
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_frames(input int target);
    while (frames_seen < target) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired frames=%0d expected more", frames_seen);
    summary();
    $finish;
  end

  initial begin
    int starts_before;
    int cs_before;
    int tmo_before;
    rst_n     = 1'b0;
    run       = 1'b0;
    period    = 16'd400;
    tmo_limit = 16'd1000;
    irq_n     = 1'b1;
    bus       = 12'h000;
    wait_cycles(5);
    // R1 reset state
    check(conv == 1'b0, "R1 start idle", 64'(conv), 64'(0));
    check(cs_n == 1'b1, "R1 chip select idle", 64'(cs_n), 64'(1));
    check(rd_n == 1'b1, "R1 read strobe idle", 64'(rd_n), 64'(1));
    check(frame == 64'd0, "R1 frame cleared", frame, 64'(0));
    check(fvalid == 1'b0 && tmo == 1'b0, "R1 strobes low", 64'({fvalid, tmo}), 64'(0));
    armed = 1;
    rst_n = 1'b1;

    // R11 no starts while run is low
    wait_cycles(500);
    check(n_starts == 0, "R11 no start without run", 64'(n_starts), 64'(0));

    // R2 periodic starts with a long period
    chk_period = 1;
    have_prev  = 0;
    run = 1'b1;
    wait_frames(4);
    run = 1'b0;
    chk_period = 0;
    wait_cycles(600);

    // R3 period shorter than one sequence
    starts_before = n_starts;
    period = 16'd100;
    run = 1'b1;
    wait_frames(8);
    run = 1'b0;
    wait_cycles(600);
    check((n_starts - starts_before) == 4, "R3 marks dropped while busy", 64'(n_starts - starts_before), 64'(4));

    // R10 silent converter
    cs_before  = cs_falls;
    tmo_before = n_tmo;
    mute = 1;
    period = 16'd400;
    tmo_limit = 16'd300;
    run = 1'b1;
    while (n_tmo < tmo_before + 2) @(negedge clk);
    run = 1'b0;
    check(int'(t_tmo - t_conv) == 301 * CLK_PERIOD, "R10 timeout instant",
          64'(int'(t_tmo - t_conv)), 64'(301 * CLK_PERIOD));
    wait_cycles(600);
    check(cs_falls == cs_before, "R10 no read after timeout", 64'(cs_falls), 64'(cs_before));
    check(frame == last_frame, "R10 frame unchanged", frame, last_frame);

    // recovery after timeouts
    mute = 0;
    tmo_limit = 16'd1000;
    run = 1'b1;
    wait_frames(10);
    run = 1'b0;
    wait_cycles(600);

    check(exp_q.size() == 0, "R9 every frame delivered", 64'(exp_q.size()), 64'(0));
    check(hold_bad == 0, "R9 frame held between strobes", 64'(hold_bad), 64'(0));
    summary();
    $finish;
  end

endmodule